// File: doc/BRIEF.md
# Serial memory page write engine

This block is the write side of a serial-memory slave on an SPI-style bus, placed in front of a small byte array. The host lowers chip-select and clocks in three parts on the data line: an opcode byte, a 16-bit address and one or more data bytes. All of it is sampled on the rising serial clock, most significant bit first. The data bytes collect in a one-page buffer. A self-timed write cycle then copies them into the array, but only if chip-select rises exactly at the end of a data byte.

The serial pins are brought into the system clock domain through two-flop synchronizers. A write-enable latch is set by a strobe from the neighbouring status logic. The write is refused in three cases: the latch is clear, a write cycle is already running, or the target page lies in the area selected by a two-bit protection input. A combinational read port exposes the array to the read path. The serial data output is never driven by this block.

Top module: `spi_page_writer`

## Requirements
- R1: After reset, `wip` and `wel` are 0, `sdo_oe` is 0 and every array byte reads 0x00.
- R2: A one-cycle `wren_set` pulse while `wip` is 0 makes `wel` read 1 on the following cycle. A pulse while `wip` is 1 has no effect.
- R3: A transaction is chip-select low, then opcode 0x02, then a 16-bit address, then data bytes, all MSB first. Only the low `ADDR_W` address bits select the byte. The first data byte goes to that address and each later byte to the next offset.
- R4: A transaction is discarded if chip-select rises in the middle of a byte or before one full data byte. In that case `wip` stays 0, the array is unchanged and `wel` keeps its value.
- R5: The page is 32 bytes. Only address bits [4:0] advance. Bytes past offset 31 wrap to offset 0 of the same page and overwrite earlier bytes of the same transaction.
- R6: After an accepted transaction, `wip` goes to 1 within 4 clocks of the chip-select rise and stays 1 for exactly `TWC` clocks. The array does not change while `wip` is 1. The new data is visible once `wip` is back at 0.
- R7: `wel` returns to 0 when each write cycle ends.
- R8: A write is ignored when `wel` is 0 at the end of the opcode byte.
- R9: A transaction whose chip-select falls while `wip` is 1 is ignored. The running write still commits its own data.
- R10: Protection input `prot`: 00 protects nothing, 01 protects addresses with top two bits 11, 10 protects addresses with top bit 1, 11 protects the whole array. A write to a protected address is ignored.
- R11: An opcode other than 0x02 is ignored. `sdo_oe` stays 0 at all times.
- R12: Bytes of the target page that the transaction did not send keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (value when driven) |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| wren_set | input | 1 | Strobe that sets the write-enable latch |
| prot | input | 2 | Block-protect selection |
| wip | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |

## Verification
Each serial pin passes through two synchronizer flops and one edge-detect flop. So `wip` rises on the third or fourth clock after the chip-select rise. It then stays high for exactly `TWC` clocks, and the array updates on the same edge that lowers it. The bench counts the clocks with `wip` high, sampling at every falling clock edge, and compares the count to `TWC`. It reads the array only after `wip` has fallen and `rd_data` has settled. A `wren_set` pulse shows on `wel` one clock later. The bench waits one full clock before reading `wel` back.

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 5,
  parameter int TWC    = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              wren_set,
  input  logic [1:0]        prot,
  output logic              wip,
  output logic              wel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(TWC + 1);

  typedef enum logic [2:0] {IDLE, OPC, ADR, DAT, SKIP} st_t;

  logic [2:0]        cs_s, ck_s, di_s;
  st_t               st;
  logic [3:0]        cnt;
  logic [14:0]       sh;
  logic [ADDR_W-1:0] ptr;
  logic              got, busy;
  logic [TW-1:0]     tmr;
  logic [PAGE-1:0]   pval;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];

  wire cs_hi   = cs_s[1];
  wire cs_fall = !cs_s[1] && cs_s[2];
  wire cs_rise = cs_s[1] && !cs_s[2];
  wire sck_up  = ck_s[1] && !ck_s[2];
  wire [15:0] sh_n = {sh, di_s[1]};
  wire unused_hi = ^sh_n[15:ADDR_W];

  function automatic logic locked(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a[ADDR_W-1:ADDR_W-2] == 2'b11;
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  assign sdo     = 1'b0;
  assign sdo_oe  = 1'b0;
  assign wip     = busy;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 3'b111;
      ck_s <= '0;
      di_s <= '0;
      st   <= IDLE;
      cnt  <= '0;
      sh   <= '0;
      ptr  <= '0;
      got  <= 1'b0;
      busy <= 1'b0;
      tmr  <= '0;
      wel  <= 1'b0;
      pval <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cs_s <= {cs_s[1:0], cs_n};
      ck_s <= {ck_s[1:0], sck};
      di_s <= {di_s[1:0], sdi};

      if (wren_set && !busy) wel <= 1'b1;

      if (cs_fall) begin
        cnt <= '0;
        if (busy) st <= SKIP;
        else begin
          st   <= OPC;
          got  <= 1'b0;
          pval <= '0;
        end
      end else if (!cs_hi && sck_up) begin
        sh  <= sh_n[14:0];
        cnt <= cnt + 4'd1;
        case (st)
          OPC: if (cnt == 4'd7) begin
            cnt <= '0;
            st  <= (sh_n[7:0] == 8'h02 && wel) ? ADR : SKIP;
          end
          ADR: if (cnt == 4'd15) begin
            cnt <= '0;
            ptr <= sh_n[ADDR_W-1:0];
            st  <= locked(prot, sh_n[ADDR_W-1:0]) ? SKIP : DAT;
          end
          DAT: if (cnt == 4'd7) begin
            cnt <= '0;
            pbuf[ptr[PAGE_W-1:0]] <= sh_n[7:0];
            pval[ptr[PAGE_W-1:0]] <= 1'b1;
            got <= 1'b1;
            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
          end
          default: ;
        endcase
      end

      if (cs_rise) st <= IDLE;

      if (cs_rise && st == DAT && cnt == 4'd0 && got && !busy) begin
        busy <= 1'b1;
        tmr  <= TW'(TWC - 1);
      end else if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          for (int i = 0; i < PAGE; i++)
            if (pval[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_page_writer_chk.sv
module spi_page_writer_chk #(
  parameter int ADDR_W = 8,
  parameter int TWC    = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wren_set,
  input logic              wip,
  input logic              wel,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data
);
  logic [31:0] hi_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_n <= '0;
    else hi_n <= wip ? hi_n + 1 : '0;

  // R6
  wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n) wip |-> hi_n < TWC);

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip) && $stable(rd_addr)) |-> $stable(rd_data));

  // R8
  start_wel_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> $past(wel));

  // R7
  end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(wip) |-> !wel);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (wren_set && !wip) |=> wel);

  // R4
  start_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> cs_n);
endmodule

bind spi_page_writer spi_page_writer_chk #(.ADDR_W(ADDR_W), .TWC(TWC)) u_chk (.*);

// File: tb/sim_spi_page_writer.sv
module sim_spi_page_writer;
  localparam int AW  = 8;
  localparam int TWC = 400;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0, wren_set = 0;
  logic [1:0] prot = 0;
  logic [AW-1:0] rd_addr = 0;
  logic sdo, sdo_oe, wip, wel;
  logic [7:0] rd_data;

  spi_page_writer #(.ADDR_W(AW), .TWC(TWC)) u0 (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] mdl [1<<AW];
  logic [7:0] dq [64];
  bit mwel = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic bit hit(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'b00: return 0;
      2'b01: return a[AW-1:AW-2] == 2'b11;
      2'b10: return a[AW-1];
      default: return 1;
    endcase
  endfunction

  function automatic bit model(input logic [7:0] op, input logic [15:0] a, input int n, input int extra);
    logic [AW-1:0] p = a[AW-1:0];
    bit ok = (op == 8'h02) && mwel && n >= 1 && extra == 0 && !hit(prot, p);
    if (ok) begin
      for (int k = 0; k < n; k++) begin
        mdl[p] = dq[k];
        p[4:0] = p[4:0] + 5'd1;
      end
      mwel = 0;
    end
    return ok;
  endfunction

  task automatic bitx(input logic b);
    @(negedge clk) sdi = b;
    repeat (3) @(negedge clk);
    sck = 1;
    repeat (4) @(negedge clk);
    sck = 0;
  endtask

  task automatic xfer(input logic [7:0] op, input logic [15:0] a, input int n, input int extra);
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) bitx(op[i]);
    for (int i = 15; i >= 0; i--) bitx(a[i]);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) bitx(dq[k][i]);
    for (int e = 0; e < extra; e++) bitx(1'b1);
    repeat (4) @(negedge clk);
    cs_n = 1;
  endtask

  task automatic set_wel();
    @(negedge clk) wren_set = 1;
    @(negedge clk) wren_set = 0;
    if (!wip) mwel = 1;
  endtask

  task automatic wait_wip(output int hi);
    hi = 0;
    for (int i = 0; i < TWC + 40; i++) begin
      @(negedge clk);
      if (wip) hi++;
      else if (hi > 0) break;
    end
  endtask

  task automatic cmp_mem(input string req);
    int miss = 0, fa = 0;
    for (int i = 0; i < (1<<AW); i++) begin
      rd_addr = AW'(i);
      #1;
      if (rd_data !== mdl[i]) begin
        if (miss == 0) fa = i;
        miss++;
      end
    end
    rd_addr = AW'(fa);
    #1;
    chk(miss == 0, req, int'(rd_data), int'(mdl[fa]));
  endtask

  task automatic run(input logic [7:0] op, input logic [15:0] a, input int n, input int extra, input string req);
    int hi;
    bit ok = model(op, a, n, extra);
    xfer(op, a, n, extra);
    wait_wip(hi);
    chk(hi == (ok ? TWC : 0), {req, " R6 wip length"}, hi, ok ? TWC : 0);
    chk(wel == mwel, {req, " R7 wel"}, int'(wel), int'(mwel));
    chk(sdo_oe == 1'b0, "R11 sdo_oe", int'(sdo_oe), 0);
    cmp_mem(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi;
    bit ok;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1<<AW); i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(wip == 0, "R1 wip", int'(wip), 0);
    chk(wel == 0, "R1 wel", int'(wel), 0);
    chk(sdo_oe == 0, "R1 sdo_oe", int'(sdo_oe), 0);
    cmp_mem("R1 array zero");

    // R8 latch clear
    dq[0] = 8'hA5;
    run(8'h02, 16'h0010, 1, 0, "R8 no latch");

    // R2 set latch, R3 single byte
    set_wel();
    @(negedge clk);
    chk(wel == 1, "R2 wel set", int'(wel), 1);
    dq[0] = 8'h3C;
    run(8'h02, 16'h0010, 1, 0, "R3 single byte");

    // R3 upper address bits ignored, multi byte
    set_wel();
    for (int k = 0; k < 5; k++) dq[k] = 8'(8'h50 + k);
    run(8'h02, 16'hF123, 5, 0, "R3 multi byte");

    // R5 wrap inside page
    set_wel();
    for (int k = 0; k < 34; k++) dq[k] = 8'(8'h80 + k);
    run(8'h02, 16'h005E, 34, 0, "R5 page wrap");

    // R12 partial page keeps neighbours
    set_wel();
    for (int k = 0; k < 3; k++) dq[k] = 8'(8'hC0 + k);
    run(8'h02, 16'h0045, 3, 0, "R12 partial page");

    // R4 mid-byte and no-data aborts
    set_wel();
    dq[0] = 8'h11; dq[1] = 8'h22;
    run(8'h02, 16'h0070, 2, 3, "R4 mid byte");
    run(8'h02, 16'h0070, 0, 0, "R4 no data");
    run(8'h02, 16'h0070, 0, 5, "R4 partial data");

    // R11 other opcode
    run(8'h03, 16'h0070, 2, 0, "R11 opcode");

    // R10 protection
    prot = 2'b01; set_wel(); dq[0] = 8'hE1;
    run(8'h02, 16'h00C0, 1, 0, "R10 quarter blocked");
    run(8'h02, 16'h00BF, 1, 0, "R10 quarter open");
    prot = 2'b10; set_wel(); dq[0] = 8'hE2;
    run(8'h02, 16'h0080, 1, 0, "R10 half blocked");
    run(8'h02, 16'h007F, 1, 0, "R10 half open");
    prot = 2'b11; set_wel(); dq[0] = 8'hE3;
    run(8'h02, 16'h0000, 1, 0, "R10 all blocked");
    prot = 2'b00;
    run(8'h02, 16'h00FF, 1, 0, "R10 none");

    // R9 write while busy; R2 strobe ignored while busy
    set_wel();
    dq[0] = 8'h77; dq[1] = 8'h78;
    ok = model(8'h02, 16'h0020, 2, 0);
    xfer(8'h02, 16'h0020, 2, 0);
    repeat (8) @(negedge clk);
    chk(wip == 1, "R6 wip raised", int'(wip), 1);
    set_wel();
    dq[0] = 8'h99;
    xfer(8'h02, 16'h0060, 1, 0);
    wait_wip(hi);
    chk(wel == 0, "R2 R9 wel after busy", int'(wel), 0);
    dq[0] = 8'h77;
    cmp_mem("R9 busy ignored");

    // random mix
    for (int t = 0; t < 16; t++) begin
      int n = int'($urandom_range(0, 36));
      int ex = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 7)) : 0;
      logic [7:0] op = ($urandom_range(0, 7) == 0) ? 8'h0B : 8'h02;
      logic [15:0] a = 16'($urandom);
      prot = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'($urandom);
      if ($urandom_range(0, 3) != 0) set_wel();
      for (int k = 0; k < n; k++) dq[k] = 8'($urandom);
      run(op, a, n, ex, "R3 R5 R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule